// File: doc/BRIEF.md
# Stream Command Decoder

This block turns a stream of 32-bit command words into actions. Each word arrives on an inbound valid/ready channel and passes through a four-state sequence: fetch, load, an optional transmit step, and done. A write command loads a small bank of LED output bits. A read command builds a reply word that carries the current LED state and sends it back on an outbound valid/ready channel. Any other opcode is consumed and dropped.

The block handles one command at a time. Inbound ready is asserted only while the machine waits for a word, so upstream back-pressure holds the word in place until the machine is free. On the outbound side, a reply is held with constant data until the consumer accepts it. While a reply waits, no further command is fetched. The LED pins are plain registered outputs. The reset is asynchronous and active low.

Top module: `stcmd_decoder`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, in_ready is 1, out_valid is 0 and leds is 0. Reset takes effect without a clock edge.
- R2: in_ready is high only while the machine waits for a command. On the cycle after a word is accepted (in_valid and in_ready both high at a rising edge), in_ready is 0, so exactly one word is taken per command.
- R3: A write command has opcode 0x01 in bits [31:24]. It copies bits [3:0] of the word to leds, and the new value is visible after the second rising edge counted from the acceptance edge. All other bits of a write are ignored.
- R4: A read command has opcode 0x02 in bits [31:24]. It produces a reply in which bits [31:24] are 0x02, bits [3:0] are the current leds value and all other bits are 0. out_valid rises after the second rising edge counted from the acceptance edge. A read leaves leds unchanged.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged. The reply is retired at the first rising edge where out_ready is high, and out_valid is 0 after that edge.
- R6: A word with any other opcode changes nothing on leds and never raises out_valid.
- R7: After a write or an unknown command, in_ready returns to 1 three edges after the acceptance edge. After a read whose reply is taken at once, in_ready returns to 1 four edges after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 32 | Inbound command word |
| in_valid | input | 1 | Inbound word is present |
| in_ready | output | 1 | Block takes the inbound word at this edge |
| out_data | output | 32 | Reply word |
| out_valid | output | 1 | Reply word is present |
| out_ready | input | 1 | Consumer takes the reply at this edge |
| leds | output | 4 | LED output bank |

## Verification
Every result is timed from the acceptance edge k. in_ready must drop by the first falling edge after k. leds and out_valid settle after edge k+1. in_ready must be back by edge k+2 for writes and unknown opcodes, and by edge k+3 for reads whose reply is taken at once. The bench applies each command from a vector table, then samples at the falling edges after k, k+1 and k+2 and compares the outputs with the expected values stored in the table. The directed tests stall out_ready for several cycles and sample at every falling edge, checking that the reply holds. They also apply an asynchronous reset in mid-run and sample it before any clock edge.

// File: rtl/stcmd_pkg.sv
package stcmd_pkg;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_LOAD  = 2'd1,
    ST_TX    = 2'd2,
    ST_DONE  = 2'd3
  } stcmd_state_e;

  typedef enum logic [1:0] {
    OPK_NONE  = 2'd0,
    OPK_WRITE = 2'd1,
    OPK_READ  = 2'd2
  } stcmd_opkind_e;

endpackage

// File: rtl/stcmd_fsm.sv
module stcmd_fsm
  import stcmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  input  stcmd_opkind_e op_kind,
  output logic          in_ready,
  output logic          out_valid,
  output logic          load_en,
  output logic          fetch_en
);

  stcmd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH: if (in_valid) state_d = ST_LOAD;
      ST_LOAD:  state_d = (op_kind == OPK_READ) ? ST_TX : ST_DONE;
      ST_TX:    if (out_ready) state_d = ST_DONE;
      ST_DONE:  state_d = ST_FETCH;
      default:  state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign in_ready  = (state_q == ST_FETCH);
  assign out_valid = (state_q == ST_TX);
  assign load_en   = (state_q == ST_LOAD);
  assign fetch_en  = in_ready && in_valid;

endmodule

// File: rtl/stcmd_instr.sv
module stcmd_instr
  import stcmd_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          OPC_W  = 8,
  parameter int          LED_W  = 4,
  parameter logic [7:0]  OPC_WR = 8'h01,
  parameter logic [7:0]  OPC_RD = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic [DATA_W-1:0] in_data,
  output stcmd_opkind_e     op_kind,
  output logic [LED_W-1:0]  led_val
);

  localparam int OPC_LSB = DATA_W - OPC_W;

  logic [DATA_W-1:0] instr_q;
  logic [OPC_W-1:0]  opc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        instr_q <= '0;
    else if (fetch_en) instr_q <= in_data;
  end

  assign opc     = instr_q[DATA_W-1:OPC_LSB];
  assign led_val = instr_q[LED_W-1:0];

  always_comb begin
    if (opc == OPC_W'(OPC_WR))      op_kind = OPK_WRITE;
    else if (opc == OPC_W'(OPC_RD)) op_kind = OPK_READ;
    else                            op_kind = OPK_NONE;
  end

endmodule

// File: rtl/stcmd_led_bank.sv
module stcmd_led_bank
  import stcmd_pkg::*;
#(
  parameter int LED_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  stcmd_opkind_e    op_kind,
  input  logic [LED_W-1:0] led_val,
  output logic [LED_W-1:0] leds
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 leds <= '0;
    else if (load_en && op_kind == OPK_WRITE)   leds <= led_val;
  end

endmodule

// File: rtl/stcmd_resp.sv
module stcmd_resp
  import stcmd_pkg::*;
#(
  parameter int         DATA_W = 32,
  parameter int         OPC_W  = 8,
  parameter int         LED_W  = 4,
  parameter logic [7:0] OPC_RD = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  stcmd_opkind_e     op_kind,
  input  logic [LED_W-1:0]  leds,
  output logic [DATA_W-1:0] out_data
);

  localparam int PAD_W = DATA_W - OPC_W - LED_W;

  logic [DATA_W-1:0] reply;

  generate
    if (PAD_W > 0) begin : g_pad
      assign reply = {OPC_W'(OPC_RD), {PAD_W{1'b0}}, leds};
    end else begin : g_nopad
      assign reply = {OPC_W'(OPC_RD), leds};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              out_data <= '0;
    else if (load_en && op_kind == OPK_READ) out_data <= reply;
  end

endmodule

// File: rtl/stcmd_decoder.sv
module stcmd_decoder
  import stcmd_pkg::*;
#(
  parameter int         DATA_W = 32,
  parameter int         OPC_W  = 8,
  parameter int         LED_W  = 4,
  parameter logic [7:0] OPC_WR = 8'h01,
  parameter logic [7:0] OPC_RD = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LED_W-1:0]  leds
);

  stcmd_opkind_e    op_kind;
  logic             load_en;
  logic             fetch_en;
  logic [LED_W-1:0] led_val;

  stcmd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .op_kind   (op_kind),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load_en   (load_en),
    .fetch_en  (fetch_en)
  );

  stcmd_instr #(
    .DATA_W (DATA_W), .OPC_W (OPC_W), .LED_W (LED_W),
    .OPC_WR (OPC_WR), .OPC_RD (OPC_RD)
  ) u_instr (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_en (fetch_en),
    .in_data  (in_data),
    .op_kind  (op_kind),
    .led_val  (led_val)
  );

  stcmd_led_bank #(.LED_W(LED_W)) u_leds (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .op_kind (op_kind),
    .led_val (led_val),
    .leds    (leds)
  );

  stcmd_resp #(
    .DATA_W (DATA_W), .OPC_W (OPC_W), .LED_W (LED_W), .OPC_RD (OPC_RD)
  ) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .op_kind  (op_kind),
    .leds     (leds),
    .out_data (out_data)
  );

endmodule

// File: rtl/stcmd_decoder_chk.sv
module stcmd_decoder_chk #(
  parameter int         DATA_W = 32,
  parameter int         OPC_W  = 8,
  parameter int         LED_W  = 4,
  parameter logic [7:0] OPC_WR = 8'h01,
  parameter logic [7:0] OPC_RD = 8'h02
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LED_W-1:0]  leds
);

  localparam int OPC_LSB = DATA_W - OPC_W;

  // Shadow of the last accepted word, one cycle behind acceptance.
  logic             acc_q;
  logic [OPC_W-1:0] opc_q;
  logic [LED_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      opc_q <= '0;
      val_q <= '0;
    end else begin
      acc_q <= in_valid && in_ready;
      if (in_valid && in_ready) begin
        opc_q <= in_data[DATA_W-1:OPC_LSB];
        val_q <= in_data[LED_W-1:0];
      end
    end
  end

  p_one_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_write_led_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && opc_q == OPC_W'(OPC_WR)) |=> (leds == $past(val_q)));

  p_led_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc_q && opc_q == OPC_W'(OPC_WR))) |=> $stable(leds));

  p_reply_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[DATA_W-1:OPC_LSB] == OPC_W'(OPC_RD)
                   && out_data[LED_W-1:0] == leds
                   && out_data[OPC_LSB-1:LED_W] == '0));

  p_read_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && opc_q == OPC_W'(OPC_RD)) |=> out_valid);

  p_no_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && opc_q != OPC_W'(OPC_RD)) |=> !out_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

endmodule

bind stcmd_decoder stcmd_decoder_chk #(
  .DATA_W (DATA_W), .OPC_W (OPC_W), .LED_W (LED_W),
  .OPC_WR (OPC_WR), .OPC_RD (OPC_RD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_data   (in_data),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .leds      (leds)
);

// File: tb/stcmd_decoder_tb.sv
`timescale 1ns/1ps
module stcmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  leds;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  stcmd_decoder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .leds      (leds)
  );

  // {word, led after, out_valid, reply, in_ready two edges after acceptance}
  localparam int NV = 10;
  localparam logic [69:0] VEC [NV] = '{
    {32'h0100_0005, 4'h5, 1'b0, 32'h0000_0000, 1'b1},  // R3 write
    {32'h0200_0000, 4'h5, 1'b1, 32'h0200_0005, 1'b0},  // R4 read
    {32'h01FF_FFFA, 4'hA, 1'b0, 32'h0000_0000, 1'b1},  // R3 extra bits ignored
    {32'h0212_3450, 4'hA, 1'b1, 32'h0200_000A, 1'b0},  // R4 payload ignored
    {32'h7F00_000F, 4'hA, 1'b0, 32'h0000_0000, 1'b1},  // R6 unknown
    {32'h0000_0003, 4'hA, 1'b0, 32'h0000_0000, 1'b1},  // R6 opcode zero
    {32'h0100_0000, 4'h0, 1'b0, 32'h0000_0000, 1'b1},  // R3 clear
    {32'h0200_0000, 4'h0, 1'b1, 32'h0200_0000, 1'b0},  // R4 read zero
    {32'h0100_000F, 4'hF, 1'b0, 32'h0000_0000, 1'b1},  // R3 all on
    {32'hFF00_0001, 4'hF, 1'b0, 32'h0000_0000, 1'b1}   // R6 opcode FF
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Returns once the word has been accepted at a rising edge.
  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_data  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 in_ready in reset", 32'(in_ready), 32'd1);
    check("R1 out_valid in reset", 32'(out_valid), 32'd0);
    check("R1 leds in reset", 32'(leds), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after reset", 32'(in_ready), 32'd1);
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][69:38]);
      @(negedge clk);
      check("R2 in_ready drops after accept", 32'(in_ready), 32'd0);
      @(negedge clk);
      check("R3/R6 leds", 32'(leds), 32'(VEC[i][37:34]));
      check("R4/R6 out_valid", 32'(out_valid), 32'(VEC[i][33]));
      if (VEC[i][33]) check("R4 reply word", out_data, VEC[i][32:1]);
      @(negedge clk);
      check("R7 in_ready timing", 32'(in_ready), 32'(VEC[i][0]));
      if (VEC[i][33]) begin
        check("R5 reply retired", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R7 in_ready after read", 32'(in_ready), 32'd1);
      end
    end

    // R5 back-pressure on the reply
    send(32'h0100_0006);
    repeat (3) @(negedge clk);
    out_ready = 1'b0;
    send(32'h0200_0000);
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      check("R5 out_valid held", 32'(out_valid), 32'd1);
      check("R5 out_data held", out_data, 32'h0200_0006);
      check("R2 no fetch while stalled", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R5 retired after ready", 32'(out_valid), 32'd0);
    @(negedge clk);
    check("R7 back to fetch", 32'(in_ready), 32'd1);

    // R1 asynchronous reset in mid-run
    send(32'h0100_0009);
    @(negedge clk);
    @(negedge clk);
    check("R3 leds before reset", 32'(leds), 32'd9);
    out_ready = 1'b0;
    send(32'h0200_0000);
    @(negedge clk);
    @(negedge clk);
    check("R4 pending before reset", 32'(out_valid), 32'd1);
    #2 rst_n = 1'b0;
    #1;
    check("R1 async leds", 32'(leds), 32'd0);
    check("R1 async out_valid", 32'(out_valid), 32'd0);
    check("R1 async in_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;

    // R2 back-to-back writes with valid held high
    @(negedge clk);
    in_data  = 32'h0100_0003;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    check("R2 one word taken", 32'(in_ready), 32'd0);
    in_data = 32'h0100_000C;
    @(negedge clk);
    @(negedge clk);
    check("R3 first of pair", 32'(leds), 32'd3);
    @(negedge clk);
    check("R7 ready for second", 32'(in_ready), 32'd1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R3 second of pair", 32'(leds), 32'hC);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule